// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs bus cycles for a single-master processor bus on which the low address bits and the data share one set of pins. A requester presents a cycle type, a word address, two byte enables and write data. The sequencer steps through four bus states, T1 to T4, and stretches the cycle with wait states while the addressed device holds READY low. It drives the address latch strobe, active-low read and write strobes, the memory/IO select, the transceiver direction and enable, the output enable of the shared lines, and a three-bit cycle-type status. It returns the captured read data with a one-clock done pulse.

Each bus state lasts two clocks, called the first and second half. The half-clock steps place the falling edge of the latch strobe while the address is still driven. They also delay the read strobe until the shared lines have floated, and end write data in the middle of T4. Every output pin comes straight from a flop.

Top module: `adbus_cycle_seq`

## Requirements
- R1: While no cycle is in progress, including right after reset, status_o is 111, ale_o is 0, rd_n_o, wr_n_o, den_n_o and bhe_n_o are 1, ad_oe_o, mio_o, dtr_o and done_o are 0.
- R2: A request is looked at only while idle. req_type_i uses the status code of the cycle: 001 I/O read, 010 I/O write, 100 opcode fetch, 101 memory read, 110 memory write. The codes 000, 011 and 111 start no cycle and leave every pin idle.
- R3: An accepted request raises ale_o in the first clock after the accepting edge, for exactly one clock. Each bus state lasts two clocks. Through both clocks of T1, ad_oe_o is 1 and ad_out_o carries {word address bits [14:0], A0}. addr_hi_o carries word address bits [18:15] from T1 to T4.
- R4: Byte select: req_be_i 11 (word) gives bhe_n_o 0 and A0 0; 01 (low byte) gives bhe_n_o 1 and A0 0; 10 (high byte) gives bhe_n_o 0 and A0 1. bhe_n_o is held from T1 to T4.
- R5: On a read, ad_oe_o is 0 from the start of T2. rd_n_o is 0 from the second half of T2 through T3 and any wait states, and returns to 1 at the start of T4.
- R6: On a write, wr_n_o is 0 from the start of T2 through T3 and any wait states. ad_out_o carries the write data with ad_oe_o 1 from the start of T2 to the end of the first half of T4.
- R7: mio_o equals type bit 2 (1 for memory) and dtr_o equals type bit 1 (1 when transmitting). Both stay constant from T1 to T4.
- R8: den_n_o is 0 only while valid data is on the shared lines: on a read while rd_n_o is 0, on a write while the write data is driven after T1.
- R9: status_o equals the cycle type from T1 through T3 and any wait states, and shows 111 in T4.
- R10: ready_i is sampled on the edge that ends T3 and on the edge that ends each wait state. When ready_i is 0 there, a two-clock wait state follows, otherwise T4 follows.
- R11: Read data is taken from ad_in_i on the edge that ends T3 or the last wait state, and is presented on rdata_o while done_o is 1.
- R12: done_o is 1 for exactly the second half of T4. The clock after it is idle.
- R13: rd_n_o is never 0 while ad_oe_o is 1, and rd_n_o and wr_n_o are never 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request a bus cycle (sampled while idle) |
| req_type_i | input | 3 | Cycle type, in the status encoding |
| req_waddr_i | input | ADDR_W-1 | Word address (byte address bits above bit 0) |
| req_be_i | input | 2 | Byte enables: bit 1 high byte, bit 0 low byte |
| req_wdata_i | input | DATA_W | Write data |
| ready_i | input | 1 | Device ready; 0 inserts wait states |
| ad_in_i | input | DATA_W | Value seen on the shared lines |
| ad_out_o | output | DATA_W | Value driven onto the shared lines |
| ad_oe_o | output | 1 | Output enable of the shared lines |
| addr_hi_o | output | ADDR_W-DATA_W | Upper address bits |
| bhe_n_o | output | 1 | High byte enable, active low |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| den_n_o | output | 1 | Transceiver enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| status_o | output | 3 | Cycle-type status |
| rdata_o | output | DATA_W | Captured read data |
| done_o | output | 1 | One-clock end-of-cycle pulse |

## Verification
The checker watches several rules on every clock. It confirms that the latch strobe is a single clock with the address still driven when it falls, that no read strobe overlaps a driven bus, and that the two strobes never meet. It also checks that the enable only comes on when the drive direction matches the transceiver direction, that the select and direction hold through a cycle, and that idle pins are quiet. The exact clock on which each strobe starts and ends, the wait-state count, the capture edge of read data and the byte-lane codes are left to the bench. The bench compares every pin on every clock against a waveform model built from the item it issued. It supplies valid read data only during the single clock before the capture edge.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } tstate_e;

    localparam logic [2:0] CT_IO_RD   = 3'b001;
    localparam logic [2:0] CT_IO_WR   = 3'b010;
    localparam logic [2:0] CT_FETCH   = 3'b100;
    localparam logic [2:0] CT_MEM_RD  = 3'b101;
    localparam logic [2:0] CT_MEM_WR  = 3'b110;
    localparam logic [2:0] CT_PASSIVE = 3'b111;

    function automatic logic type_ok(input logic [2:0] t);
        return (t == CT_IO_RD) || (t == CT_IO_WR) || (t == CT_FETCH) ||
               (t == CT_MEM_RD) || (t == CT_MEM_WR);
    endfunction

endpackage

// File: rtl/adbus_phase_ctrl.sv
module adbus_phase_ctrl
    import adbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic [2:0]        req_type_i,
    input  logic [ADDR_W-2:0] req_waddr_i,
    input  logic [1:0]        req_be_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] ad_in_i,
    output tstate_e           nxt_state_o,
    output logic              nxt_half_o,
    output logic [2:0]        nxt_type_o,
    output logic [ADDR_W-2:0] nxt_waddr_o,
    output logic [1:0]        nxt_be_o,
    output logic [DATA_W-1:0] nxt_wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);

    typedef struct packed {
        tstate_e           state;
        logic              half;
        logic [2:0]        ctype;
        logic [ADDR_W-2:0] waddr;
        logic [1:0]        be;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.half = 1'b0;
                if (req_i && type_ok(req_type_i)) begin
                    ctl_d.state = ST_T1;
                    ctl_d.ctype = req_type_i;
                    ctl_d.waddr = req_waddr_i;
                    ctl_d.be    = req_be_i;
                    ctl_d.wdata = req_wdata_i;
                end
            end
            ST_T1, ST_T2: begin
                ctl_d.half = ~ctl_q.half;
                if (ctl_q.half) begin
                    ctl_d.state = (ctl_q.state == ST_T1) ? ST_T2 : ST_T3;
                end
            end
            ST_T3, ST_TW: begin
                ctl_d.half = ~ctl_q.half;
                if (ctl_q.half) begin
                    if (ready_i) begin
                        ctl_d.state = ST_T4;
                        ctl_d.rdata = ad_in_i;
                    end else begin
                        ctl_d.state = ST_TW;
                    end
                end
            end
            ST_T4: begin
                ctl_d.half = ~ctl_q.half;
                if (!ctl_q.half) begin
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
                ctl_d.half  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.ctype <= CT_PASSIVE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign nxt_state_o = ctl_d.state;
    assign nxt_half_o  = ctl_d.half;
    assign nxt_type_o  = ctl_d.ctype;
    assign nxt_waddr_o = ctl_d.waddr;
    assign nxt_be_o    = ctl_d.be;
    assign nxt_wdata_o = ctl_d.wdata;
    assign rdata_o     = ctl_q.rdata;
    assign done_o      = ctl_q.done;

endmodule

// File: rtl/adbus_strobe_gen.sv
module adbus_strobe_gen
    import adbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  tstate_e                  state_i,
    input  logic                     half_i,
    input  logic [2:0]               type_i,
    input  logic [ADDR_W-2:0]        waddr_i,
    input  logic [1:0]               be_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        ad_out_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                     bhe_n_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic                     den_n_o,
    output logic                     dtr_o,
    output logic                     mio_o,
    output logic [2:0]               status_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] ad;
        logic              oe;
        logic [HI_W-1:0]   addr_hi;
        logic              bhe_n;
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic              den_n;
        logic              dtr;
        logic              mio;
        logic [2:0]        status;
    } pins_t;

    localparam pins_t PINS_IDLE = '{
        ad: '0, oe: 1'b0, addr_hi: '0, bhe_n: 1'b1, ale: 1'b0,
        rd_n: 1'b1, wr_n: 1'b1, den_n: 1'b1, dtr: 1'b0, mio: 1'b0,
        status: CT_PASSIVE
    };

    pins_t pins_d, pins_q;

    logic in_cyc, is_wr, in_t1, in_t2, in_mid, in_t4;
    logic rd_act, wr_act, drive;

    always_comb begin
        in_cyc = (state_i != ST_IDLE);
        is_wr  = type_i[1];
        in_t1  = (state_i == ST_T1);
        in_t2  = (state_i == ST_T2);
        in_mid = (state_i == ST_T3) || (state_i == ST_TW);
        in_t4  = (state_i == ST_T4);

        rd_act = !is_wr && ((in_t2 && half_i) || in_mid);
        wr_act = is_wr && (in_t2 || in_mid);
        drive  = in_t1 || (is_wr && (in_t2 || in_mid || (in_t4 && !half_i)));

        pins_d = PINS_IDLE;
        if (in_cyc) begin
            pins_d.mio     = type_i[2];
            pins_d.dtr     = type_i[1];
            pins_d.bhe_n   = ~be_i[1];
            pins_d.addr_hi = waddr_i[ADDR_W-2:DATA_W-1];
            pins_d.status  = in_t4 ? CT_PASSIVE : type_i;
            pins_d.ale     = in_t1 && !half_i;
            pins_d.rd_n    = ~rd_act;
            pins_d.wr_n    = ~wr_act;
            pins_d.den_n   = ~(rd_act || (drive && !in_t1));
            pins_d.oe      = drive;
            if (in_t1) begin
                pins_d.ad = {waddr_i[DATA_W-2:0], ~be_i[0]};
            end else if (drive) begin
                pins_d.ad = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pins_q <= PINS_IDLE;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign ad_out_o  = pins_q.ad;
    assign ad_oe_o   = pins_q.oe;
    assign addr_hi_o = pins_q.addr_hi;
    assign bhe_n_o   = pins_q.bhe_n;
    assign ale_o     = pins_q.ale;
    assign rd_n_o    = pins_q.rd_n;
    assign wr_n_o    = pins_q.wr_n;
    assign den_n_o   = pins_q.den_n;
    assign dtr_o     = pins_q.dtr;
    assign mio_o     = pins_q.mio;
    assign status_o  = pins_q.status;

endmodule

// File: rtl/adbus_cycle_seq.sv
module adbus_cycle_seq
    import adbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     req_i,
    input  logic [2:0]               req_type_i,
    input  logic [ADDR_W-2:0]        req_waddr_i,
    input  logic [1:0]               req_be_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    input  logic                     ready_i,
    input  logic [DATA_W-1:0]        ad_in_i,
    output logic [DATA_W-1:0]        ad_out_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                     bhe_n_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic                     den_n_o,
    output logic                     dtr_o,
    output logic                     mio_o,
    output logic [2:0]               status_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     done_o
);

    tstate_e           nxt_state;
    logic              nxt_half;
    logic [2:0]        nxt_type;
    logic [ADDR_W-2:0] nxt_waddr;
    logic [1:0]        nxt_be;
    logic [DATA_W-1:0] nxt_wdata;

    adbus_phase_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_phase (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .req_i       (req_i),
        .req_type_i  (req_type_i),
        .req_waddr_i (req_waddr_i),
        .req_be_i    (req_be_i),
        .req_wdata_i (req_wdata_i),
        .ready_i     (ready_i),
        .ad_in_i     (ad_in_i),
        .nxt_state_o (nxt_state),
        .nxt_half_o  (nxt_half),
        .nxt_type_o  (nxt_type),
        .nxt_waddr_o (nxt_waddr),
        .nxt_be_o    (nxt_be),
        .nxt_wdata_o (nxt_wdata),
        .rdata_o     (rdata_o),
        .done_o      (done_o)
    );

    adbus_strobe_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_strobe (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .state_i   (nxt_state),
        .half_i    (nxt_half),
        .type_i    (nxt_type),
        .waddr_i   (nxt_waddr),
        .be_i      (nxt_be),
        .wdata_i   (nxt_wdata),
        .ad_out_o  (ad_out_o),
        .ad_oe_o   (ad_oe_o),
        .addr_hi_o (addr_hi_o),
        .bhe_n_o   (bhe_n_o),
        .ale_o     (ale_o),
        .rd_n_o    (rd_n_o),
        .wr_n_o    (wr_n_o),
        .den_n_o   (den_n_o),
        .dtr_o     (dtr_o),
        .mio_o     (mio_o),
        .status_o  (status_o)
    );

endmodule

// File: rtl/adbus_cycle_chk.sv
module adbus_cycle_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ale_o,
    input logic       rd_n_o,
    input logic       wr_n_o,
    input logic       den_n_o,
    input logic       dtr_o,
    input logic       mio_o,
    input logic       ad_oe_o,
    input logic [2:0] status_o,
    input logic       done_o
);

    logic cyc_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cyc_q <= 1'b0;
        end else if (ale_o) begin
            cyc_q <= 1'b1;
        end else if (done_o) begin
            cyc_q <= 1'b0;
        end
    end

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cyc_q && !ale_o) |-> (status_o == 3'b111 && rd_n_o && wr_n_o &&
                                den_n_o && !ad_oe_o && !done_o));

    a_r3_ale_single: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |=> (!ale_o && ad_oe_o));

    a_r3_ale_with_addr: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |-> ad_oe_o);

    a_r6_write_drives: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_n_o |-> (ad_oe_o && dtr_o));

    a_r7_select_stable: assert property (@(posedge clk_i) disable iff (rst_i)
        cyc_q |-> ($stable(mio_o) && $stable(dtr_o)));

    a_r8_den_direction: assert property (@(posedge clk_i) disable iff (rst_i)
        !den_n_o |-> (ad_oe_o == dtr_o));

    a_r9_status_active: assert property (@(posedge clk_i) disable iff (rst_i)
        ale_o |-> (status_o != 3'b111));

    a_r12_done_single: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> (!done_o && status_o == 3'b111));

    a_r12_done_in_cycle: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> (cyc_q && status_o == 3'b111));

    a_r13_read_floats: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_n_o |-> !ad_oe_o);

    a_r13_strobes_apart: assert property (@(posedge clk_i) disable iff (rst_i)
        !(!rd_n_o && !wr_n_o));

endmodule

bind adbus_cycle_seq adbus_cycle_chk u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .ale_o    (ale_o),
    .rd_n_o   (rd_n_o),
    .wr_n_o   (wr_n_o),
    .den_n_o  (den_n_o),
    .dtr_o    (dtr_o),
    .mio_o    (mio_o),
    .ad_oe_o  (ad_oe_o),
    .status_o (status_o),
    .done_o   (done_o)
);

// File: tb/adbus_cycle_seq_tb.sv
`timescale 1ns/1ps
module adbus_cycle_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [2:0]  req_type = 3'b111;
    logic [18:0] req_waddr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0;
    logic        ready = 1'b1;
    logic [15:0] ad_in = 16'hDEAD;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  addr_hi;
    logic        bhe_n, ale, rd_n, wr_n, den_n, dtr, mio, done;
    logic [2:0]  status;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    adbus_cycle_seq u_dut (
        .clk_i(clk), .rst_i(rst), .req_i(req), .req_type_i(req_type),
        .req_waddr_i(req_waddr), .req_be_i(req_be), .req_wdata_i(req_wdata),
        .ready_i(ready), .ad_in_i(ad_in), .ad_out_o(ad_out), .ad_oe_o(ad_oe),
        .addr_hi_o(addr_hi), .bhe_n_o(bhe_n), .ale_o(ale), .rd_n_o(rd_n),
        .wr_n_o(wr_n), .den_n_o(den_n), .dtr_o(dtr), .mio_o(mio),
        .status_o(status), .rdata_o(rdata), .done_o(done)
    );

    typedef struct {
        logic [2:0]  t;
        logic [18:0] wa;
        logic [1:0]  be;
        logic [15:0] wd;
        logic [15:0] rd;
        int          w;
    } item_t;

    item_t sb_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: issues one cycle, pushes the expected item, plays READY and read data.
    task automatic run_cycle(input logic [2:0] t, input logic [18:0] wa, input logic [1:0] be,
                             input logic [15:0] wd, input logic [15:0] rdv, input int w);
        item_t it;
        @(negedge clk);
        it.t = t; it.wa = wa; it.be = be; it.wd = wd; it.rd = rdv; it.w = w;
        sb_q.push_back(it);
        req = 1'b1; req_type = t; req_waddr = wa; req_be = be; req_wdata = wd;
        ready = 1'b1; ad_in = 16'hDEAD;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 8 + 2 * w; k++) begin
            ready = (k >= 5 + 2 * w);
            ad_in = (k == 5 + 2 * w) ? rdv : (16'hDEAD ^ 16'(k));
            @(negedge clk);
        end
        ready = 1'b1;
    endtask

    // R2: types outside the accepted set start nothing.
    task automatic ignore_type(input logic [2:0] t);
        @(negedge clk);
        req = 1'b1; req_type = t; req_waddr = 19'h5A5A5; req_be = 2'b11;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk("R2 no ale for bad type", 32'(ale), 32'd0);
            chk("R2 status passive for bad type", 32'(status), 32'd7);
            @(negedge clk);
        end
    endtask

    // Monitor: pops the expected item on ALE and compares every pin per clock.
    item_t cur;
    int    kk = 0;
    bit    act = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!act) begin
                if (ale) begin
                    if (sb_q.size() == 0) begin
                        chk("R2 unexpected cycle", 32'd1, 32'd0);
                    end else begin
                        cur = sb_q.pop_front();
                        kk = 0;
                        act = 1;
                    end
                end else begin
                    chk("R1 idle status", 32'(status), 32'd7);
                    chk("R1 idle strobes", {ale, rd_n, wr_n, den_n, bhe_n, ad_oe, mio, dtr, done},
                        9'b011110000);
                end
            end
            if (act) begin
                automatic int  w   = cur.w;
                automatic bit  t1  = (kk < 2);
                automatic bit  t2  = (kk >= 2 && kk < 4);
                automatic bit  t3  = (kk >= 4 && kk < 6);
                automatic bit  tw  = (kk >= 6 && kk < 6 + 2 * w);
                automatic bit  t4  = (kk >= 6 + 2 * w);
                automatic bit  h   = kk[0];
                automatic bit  wrc = cur.t[1];
                automatic bit  e_rd  = !wrc && ((t2 && h) || t3 || tw);
                automatic bit  e_wr  = wrc && (t2 || t3 || tw);
                automatic bit  e_oe  = t1 || (wrc && (t2 || t3 || tw || (t4 && !h)));
                automatic bit  e_den = e_rd || (wrc && e_oe && !t1);
                chk("R3 ale pulse", 32'(ale), 32'(kk == 0));
                chk("R5 read strobe", 32'(rd_n), 32'(!e_rd));
                chk("R6 write strobe", 32'(wr_n), 32'(!e_wr));
                chk("R3 R5 R6 bus drive", 32'(ad_oe), 32'(e_oe));
                chk("R8 buffer enable", 32'(den_n), 32'(!e_den));
                chk("R7 mio", 32'(mio), 32'(cur.t[2]));
                chk("R7 dtr", 32'(dtr), 32'(cur.t[1]));
                chk("R9 status", 32'(status), t4 ? 32'd7 : 32'(cur.t));
                chk("R4 bhe_n", 32'(bhe_n), 32'(!cur.be[1]));
                chk("R3 upper address", 32'(addr_hi), 32'(cur.wa[18:15]));
                chk("R13 no read contention", 32'(!rd_n && ad_oe), 32'd0);
                if (t1) chk("R3 R4 address and A0", 32'(ad_out), 32'({cur.wa[14:0], !cur.be[0]}));
                else if (e_oe) chk("R6 write data", 32'(ad_out), 32'(cur.wd));
                chk("R10 R12 done timing", 32'(done), 32'(kk == 7 + 2 * w));
                if (done && !wrc) chk("R11 read data", 32'(rdata), 32'(cur.rd));
                if (kk == 7 + 2 * w) act = 0;
                else kk++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk("R12 watchdog expired", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        chk("R1 reset status", 32'(status), 32'd7);
        chk("R1 reset strobes", {ale, rd_n, wr_n, den_n, ad_oe, done}, 6'b011100);

        run_cycle(3'b101, 19'h12345, 2'b11, 16'h0000, 16'hBEEF, 0); // memory read word
        run_cycle(3'b110, 19'h0ABCD, 2'b11, 16'hC0DE, 16'h0000, 0); // memory write word
        run_cycle(3'b001, 19'h00F0F, 2'b01, 16'h0000, 16'h00A5, 2); // I/O read low byte, waits
        run_cycle(3'b010, 19'h00333, 2'b10, 16'h5A00, 16'h0000, 1); // I/O write high byte
        run_cycle(3'b100, 19'h7FFFF, 2'b11, 16'h0000, 16'h9090, 3); // opcode fetch
        run_cycle(3'b110, 19'h40001, 2'b01, 16'h0077, 16'h0000, 2); // memory write low byte
        run_cycle(3'b101, 19'h2AAAA, 2'b10, 16'h0000, 16'h1200, 0); // memory read high byte
        ignore_type(3'b000);
        ignore_type(3'b011);
        ignore_type(3'b111);
        run_cycle(3'b001, 19'h00001, 2'b11, 16'h0000, 16'h4321, 5); // long wait
        repeat (3) @(negedge clk);
        chk("R2 scoreboard drained", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule